// File: doc/BRIEF.md
# Four-Pin Bridge PWM Generator

This block produces one pulse-width-modulated waveform with 10-bit duty resolution. It steers that waveform to four output pins, A to D, in one of four arrangements: a single modulated pin, a complementary pair for a half bridge, or one of two diagonal patterns for a full bridge. In the full-bridge forward arrangement, A stays on and D is modulated. In the reverse arrangement, C stays on and B is modulated. Dead-band insertion is left to a companion stage that sits after the pins.

The timebase is internal. A prescaler divides the input clock by 1, 4 or 16. Each prescaler tick advances a 2-bit fine counter, and each wrap of that counter advances an 8-bit coarse timer. The timer runs from zero up to the programmed period value and then restarts. The 10-bit count is the coarse timer joined with the fine counter, and it is compared against the duty value.

All five control inputs (period, duty, prescale, arrangement and polarity) are captured only at the end of a period. Software can change them at any time without producing a truncated pulse or a glitch on the pins.

Top module: `bridge_pwm`

## Requirements
- R1: While reset is asserted, and after it is released until the first capture, all four pins are low. The captured configuration is all zeros: period 0, duty 0, prescale /1, arrangement 00, active-high.
- R2: Arrangement code 00 modulates pin A and holds pins B, C and D at the inactive level.
- R3: Arrangement code 10 drives the modulated level on A and its complement on B, and holds C and D inactive.
- R4: Arrangement code 01 holds A at the active level, modulates D, and holds B and C inactive.
- R5: Arrangement code 11 holds C at the active level, modulates B, and holds A and D inactive.
- R6: One period lasts 4 × P × (period + 1) input clocks, where P is the prescale factor.
- R7: The modulated level is active for the first duty × P clocks of each period and inactive for the rest. With duty 0 it is never active. With duty ≥ 4 × (period + 1) it is active for the whole period.
- R8: Prescale code 00 gives P = 1, code 01 gives P = 4, and codes 10 and 11 both give P = 16.
- R9: Polarity input 1 inverts the level of all four pins relative to polarity 0. The active level is then low.
- R10: Changes to period, duty, prescale, arrangement or polarity have no effect on the pins until the clock edge that ends the current period.
- R11: Pin bit order on the output bus is {D, C, B, A}, with A at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | 8 | Coarse timer terminal value |
| duty_i | input | 10 | Duty count in prescaled clocks |
| presc_i | input | 2 | Prescale code |
| mode_i | input | 2 | Arrangement code |
| invert_i | input | 1 | 1 selects active-low pins |
| pins_o | output | 4 | Pin levels {D, C, B, A} |

## Verification
The bench builds the block with its default parameters: an 8-bit coarse timer, a 2-bit fine counter, and prescale factors of 4 and 16. Because the bench keeps the period register small (0 to 7), a period lasts at most a few hundred clocks even at /16. This lets every prescale code, both duty extremes, and mid-period reconfiguration be observed across several consecutive periods within a short run. A cycle-level reference model derives the expected pins from the period formula and compares the pins on every clock.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

    typedef enum logic [1:0] {
        BR_SINGLE = 2'b00,
        BR_FWD    = 2'b01,
        BR_HALF   = 2'b10,
        BR_REV    = 2'b11
    } br_mode_e;

    // Map the modulated level onto pins {D, C, B, A}, then apply polarity.
    function automatic logic [3:0] steer_pins(input logic lvl, input br_mode_e m,
                                              input logic inv);
        logic [3:0] act;
        unique case (m)
            BR_SINGLE: act = {3'b000, lvl};
            BR_HALF:   act = {2'b00, ~lvl, lvl};
            BR_FWD:    act = {lvl, 2'b00, 1'b1};
            BR_REV:    act = {1'b0, 1'b1, lvl, 1'b0};
            default:   act = 4'b0000;
        endcase
        return inv ? ~act : act;
    endfunction

endpackage

// File: rtl/bpwm_shadow.sv
module bpwm_shadow #(
    parameter int TMR_W  = 8,
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TMR_W-1:0]  per_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [1:0]        presc_i,
    input  logic [1:0]        mode_i,
    input  logic              inv_i,
    output logic [TMR_W-1:0]  per_q,
    output logic [1:0]        presc_q,
    output logic [DUTY_W-1:0] duty_d,
    output logic [DUTY_W-1:0] duty_q,
    output logic [1:0]        mode_d,
    output logic [1:0]        mode_q,
    output logic              inv_d,
    output logic              inv_q
);

    typedef struct packed {
        logic [TMR_W-1:0]  per;
        logic [DUTY_W-1:0] duty;
        logic [1:0]        presc;
        logic [1:0]        mode;
        logic              inv;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.per   = per_i;
            cfg_d.duty  = duty_i;
            cfg_d.presc = presc_i;
            cfg_d.mode  = mode_i;
            cfg_d.inv   = inv_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign per_q   = cfg_q.per;
    assign presc_q = cfg_q.presc;
    assign duty_d  = cfg_d.duty;
    assign duty_q  = cfg_q.duty;
    assign mode_d  = cfg_d.mode;
    assign mode_q  = cfg_q.mode;
    assign inv_d   = cfg_d.inv;
    assign inv_q   = cfg_q.inv;

    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(cfg_q.per) && $stable(cfg_q.duty) && $stable(cfg_q.presc)
                   && $stable(cfg_q.mode) && $stable(cfg_q.inv))); // R10

endmodule

// File: rtl/bpwm_timebase.sv
module bpwm_timebase #(
    parameter int TMR_W     = 8,
    parameter int SUB_W     = 2,
    parameter int PRESC_MID = 4,
    parameter int PRESC_MAX = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TMR_W-1:0]       per_q,
    input  logic [1:0]             presc_q,
    output logic                   wrap_o,
    output logic [TMR_W+SUB_W-1:0] cnt_d_o,
    output logic [TMR_W+SUB_W-1:0] cnt_q_o
);

    localparam int PRE_W = (PRESC_MAX > 1) ? $clog2(PRESC_MAX) : 1;
    localparam logic [PRE_W-1:0] LAST_MID = PRE_W'(PRESC_MID - 1);
    localparam logic [PRE_W-1:0] LAST_MAX = PRE_W'(PRESC_MAX - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = {SUB_W{1'b1}};

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [TMR_W-1:0] tmr;
        logic [SUB_W-1:0] sub;
    } tb_t;

    tb_t tb_d, tb_q;
    logic [PRE_W-1:0] pre_last;
    logic tick;
    logic wrap;

    always_comb begin
        unique case (presc_q)
            2'b00:   pre_last = '0;
            2'b01:   pre_last = LAST_MID;
            default: pre_last = LAST_MAX;
        endcase
        tick = (tb_q.pre == pre_last);
        wrap = 1'b0;
        tb_d = tb_q;
        if (tick) begin
            tb_d.pre = '0;
            if (tb_q.sub == SUB_LAST) begin
                tb_d.sub = '0;
                if (tb_q.tmr == per_q) begin
                    tb_d.tmr = '0;
                    wrap     = 1'b1;
                end else begin
                    tb_d.tmr = tb_q.tmr + 1'b1;
                end
            end else begin
                tb_d.sub = tb_q.sub + 1'b1;
            end
        end else begin
            tb_d.pre = tb_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign wrap_o  = wrap;
    assign cnt_d_o = {tb_d.tmr, tb_d.sub};
    assign cnt_q_o = {tb_q.tmr, tb_q.sub};

    AST_TMR_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        tb_q.tmr <= per_q); // R6
    AST_SUB_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tb_q.sub)); // R8
    AST_WRAP_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (tb_q.tmr == '0 && tb_q.sub == '0 && tb_q.pre == '0)); // R6

endmodule

// File: rtl/bpwm_outstage.sv
module bpwm_outstage
    import bpwm_pkg::*;
#(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] cnt_d,
    input  logic [DUTY_W-1:0] cnt_q,
    input  logic [DUTY_W-1:0] duty_d,
    input  logic [DUTY_W-1:0] duty_q,
    input  logic [1:0]        mode_d,
    input  logic [1:0]        mode_q,
    input  logic              inv_d,
    input  logic              inv_q,
    output logic [3:0]        pins_o
);

    typedef struct packed {
        logic       lvl;
        logic [3:0] pins;
    } os_t;

    os_t os_d, os_q;

    always_comb begin
        os_d.lvl  = (cnt_d < duty_d);
        os_d.pins = steer_pins(os_d.lvl, br_mode_e'(mode_d), inv_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) os_q <= '0;
        else        os_q <= os_d;
    end

    assign pins_o = os_q.pins;

    AST_ZERO_DUTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |-> !os_q.lvl); // R7
    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(os_q.lvl) |-> (cnt_q == '0)); // R7
    AST_SINGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BR_SINGLE) |-> (os_q.pins[3:1] == {3{inv_q}})); // R2
    AST_HALF_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BR_HALF) |-> (os_q.pins[0] != os_q.pins[1]
                                 && os_q.pins[3:2] == {2{inv_q}})); // R3
    AST_FWD_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BR_FWD) |-> (os_q.pins[0] != inv_q
                                && os_q.pins[2:1] == {2{inv_q}})); // R4
    AST_REV_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BR_REV) |-> (os_q.pins[2] != inv_q
                                && os_q.pins[0] == inv_q && os_q.pins[3] == inv_q)); // R5

endmodule

// File: rtl/bridge_pwm.sv
module bridge_pwm #(
    parameter int TMR_W     = 8,
    parameter int SUB_W     = 2,
    parameter int PRESC_MID = 4,
    parameter int PRESC_MAX = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TMR_W-1:0]       period_i,
    input  logic [TMR_W+SUB_W-1:0] duty_i,
    input  logic [1:0]             presc_i,
    input  logic [1:0]             mode_i,
    input  logic                   invert_i,
    output logic [3:0]             pins_o
);

    localparam int DUTY_W = TMR_W + SUB_W;

    logic              wrap;
    logic [TMR_W-1:0]  per_q;
    logic [1:0]        presc_q;
    logic [DUTY_W-1:0] duty_d, duty_q;
    logic [1:0]        mode_d, mode_q;
    logic              inv_d, inv_q;
    logic [DUTY_W-1:0] cnt_d, cnt_q;

    bpwm_shadow #(.TMR_W(TMR_W), .DUTY_W(DUTY_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wrap),
        .per_i   (period_i),
        .duty_i  (duty_i),
        .presc_i (presc_i),
        .mode_i  (mode_i),
        .inv_i   (invert_i),
        .per_q   (per_q),
        .presc_q (presc_q),
        .duty_d  (duty_d),
        .duty_q  (duty_q),
        .mode_d  (mode_d),
        .mode_q  (mode_q),
        .inv_d   (inv_d),
        .inv_q   (inv_q)
    );

    bpwm_timebase #(
        .TMR_W(TMR_W), .SUB_W(SUB_W), .PRESC_MID(PRESC_MID), .PRESC_MAX(PRESC_MAX)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .per_q   (per_q),
        .presc_q (presc_q),
        .wrap_o  (wrap),
        .cnt_d_o (cnt_d),
        .cnt_q_o (cnt_q)
    );

    bpwm_outstage #(.DUTY_W(DUTY_W)) u_outstage (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_d  (cnt_d),
        .cnt_q  (cnt_q),
        .duty_d (duty_d),
        .duty_q (duty_q),
        .mode_d (mode_d),
        .mode_q (mode_q),
        .inv_d  (inv_d),
        .inv_q  (inv_q),
        .pins_o (pins_o)
    );

    AST_RESET_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pins_o == 4'b0000)); // R1

endmodule

// File: tb/tb_bridge_pwm.sv
module tb_bridge_pwm;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] period_i;
    logic [9:0] duty_i;
    logic [1:0] presc_i;
    logic [1:0] mode_i;
    logic       invert_i;
    logic [3:0] pins_o;

    always #10 clk = ~clk;  // 50 MHz

    bridge_pwm dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .duty_i   (duty_i),
        .presc_i  (presc_i),
        .mode_i   (mode_i),
        .invert_i (invert_i),
        .pins_o   (pins_o)
    );

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    vectors = 0;
    int    errors  = 0;
    bit    done    = 0;
    string tag     = "R1 reset";

    // Reference state: clock position within the period and captured settings.
    int         pos    = 0;
    int         m_ps   = 1;
    int         m_len  = 4;
    int         m_duty = 0;
    logic [1:0] m_mode = 2'b00;
    bit         m_inv  = 0;

    function automatic int factor(input logic [1:0] code);  // R8
        if (code == 2'b00) return 1;
        if (code == 2'b01) return 4;
        return 16;
    endfunction

    function automatic logic [3:0] expect_pins(input bit on, input logic [1:0] m,
                                               input bit inv);
        bit a, b, c, d;
        a = 0; b = 0; c = 0; d = 0;
        if (m == 2'b00)      a = on;                  // R2
        else if (m == 2'b10) begin a = on; b = !on; end  // R3
        else if (m == 2'b01) begin a = 1; d = on; end    // R4
        else                 begin c = 1; b = on; end    // R5
        if (inv) begin a = !a; b = !b; c = !c; d = !d; end  // R9
        return {d, c, b, a};  // R11 bit order
    endfunction

    // Driver of expectations: advance the reference by one clock and queue the result.
    always @(posedge clk) begin
        if (rst_n === 1'b1) begin
            item_t it;
            if (pos == m_len - 1) begin  // R6, R10: capture only at period end
                pos    = 0;
                m_ps   = factor(presc_i);
                m_len  = 4 * m_ps * (int'(period_i) + 1);
                m_duty = int'(duty_i);
                m_mode = mode_i;
                m_inv  = invert_i;
            end else begin
                pos = pos + 1;
            end
            it.exp = expect_pins(((pos / m_ps) < m_duty), m_mode, m_inv);  // R7
            it.tag = tag;
            q.push_back(it);
        end
    end

    // Monitor: compare one queued item per clock, away from the active edge.
    always @(negedge clk) begin
        if (q.size() > 0 && !done) begin
            item_t it;
            it = q.pop_front();
            vectors++;
            if (pins_o !== it.exp) begin
                errors++;
                $display("FAIL %s: pins=%b expected %b", it.tag, pins_o, it.exp);
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: pins=%b expected run to complete", pins_o);
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        period_i = 8'd3;
        duty_i   = 10'd5;
        presc_i  = 2'b00;
        mode_i   = 2'b00;
        invert_i = 1'b0;
        run(3);
        vectors++;  // R1: pins low in reset
        if (pins_o !== 4'b0000) begin
            errors++;
            $display("FAIL R1: pins=%b expected %b", pins_o, 4'b0000);
        end
        rst_n = 1'b1;
        tag = "R1 first period"; run(4);
        tag = "R2 single";       run(40);
        tag = "R3 half";         mode_i = 2'b10; duty_i = 10'd7;  run(40);
        tag = "R4 forward";      mode_i = 2'b01; duty_i = 10'd9;  run(40);
        tag = "R5 reverse";      mode_i = 2'b11; duty_i = 10'd3;  run(40);
        tag = "R6 period 7";     mode_i = 2'b10; period_i = 8'd7; duty_i = 10'd13; run(100);
        tag = "R8 prescale 01";  presc_i = 2'b01; period_i = 8'd2; duty_i = 10'd5; run(160);
        tag = "R8 prescale 10";  presc_i = 2'b10; run(420);
        tag = "R8 prescale 11";  presc_i = 2'b11; period_i = 8'd0; duty_i = 10'd2; run(200);
        presc_i = 2'b00; period_i = 8'd3;
        tag = "R7 zero duty";    mode_i = 2'b00; duty_i = 10'd0;   run(70);
        tag = "R7 full duty";    mode_i = 2'b11; duty_i = 10'd200; run(40);
        tag = "R7 duty at edge"; mode_i = 2'b10; duty_i = 10'd16;  run(40);
        tag = "R7 duty one";     duty_i = 10'd1; run(40);
        invert_i = 1'b1;
        for (int m = 0; m < 4; m++) begin
            tag = "R9 inverted";
            mode_i = 2'(m); duty_i = 10'(3 + m);
            run(40);
        end
        invert_i = 1'b0;
        tag = "R10 midperiod";   mode_i = 2'b01; duty_i = 10'd4; run(40);
        run(5);
        mode_i = 2'b10; duty_i = 10'd11; period_i = 8'd5; run(3);
        mode_i = 2'b11; invert_i = 1'b1; run(3);
        invert_i = 1'b0; run(80);
        run(2);
        finish_run();
    end

endmodule